// File: doc/BRIEF.md
# Clock Replacement Victim Selector

This block picks which resident page frame to evict, using the second-chance clock policy. It keeps one reference bit for each of `N_FRAMES` frames. The frames form a ring, and a single hand points at the next candidate. Each reported access sets the reference bit of the frame it names.

When the block accepts a victim request, it sweeps around the ring from the hand, looking at one frame per clock. A frame whose bit is set loses the bit and is passed over. The first frame found with a clear bit becomes the victim. The block treats that frame as refilled at once: it sets the frame's bit and moves the hand one place beyond it.

The caller raises `vsel_req` while `vsel_busy` is low. It then waits for the one-cycle `vsel_done` pulse and reads the victim index `vsel_frame` in that same cycle. Accesses may arrive at any time, including during a sweep.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset all reference bits are 0, the hand points at frame 0, and both `vsel_busy` and `vsel_done` are low. The first request after reset therefore returns frame 0 after a one-frame sweep.
- R2: A cycle with `touch_valid` high sets the reference bit of frame `touch_frame`.
- R3: A sweep starts at the hand and examines one frame per clock. The first examined frame whose bit is 0 is returned as the victim.
- R4: An examined frame whose bit is 1 has that bit cleared and is skipped, and the hand moves on to the next frame.
- R5: The frame returned as victim has its reference bit set to 1, because it now holds the newly loaded page.
- R6: After a victim is chosen, the hand points at the frame following it. The hand wraps from frame N_FRAMES-1 to frame 0.
- R7: If every bit is set and no access interferes, the sweep clears all bits and returns the frame that was under the hand. It examines N_FRAMES+1 frames to do so.
- R8: If an access names the frame being cleared in the same cycle, the access wins and the bit stays set.
- R9: `vsel_done` is high for exactly one cycle, and `vsel_frame` is valid during that cycle. `vsel_busy` is high from the cycle after the request is accepted until the pulse.
- R10: A `vsel_req` that arrives while `vsel_busy` is high is ignored and produces no extra victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_valid | input | 1 | An access to a resident frame happens this cycle |
| touch_frame | input | IDX_W | Index of the accessed frame |
| vsel_req | input | 1 | Request for a victim; accepted only when not busy |
| vsel_busy | output | 1 | A sweep is in progress |
| vsel_done | output | 1 | One-cycle pulse: the victim index is valid |
| vsel_frame | output | IDX_W | Index of the chosen victim |

## Verification
A wrong reference bit or a misplaced hand does not stay hidden. It changes both the returned index and the number of cycles between the request and `vsel_done` on the next request that reaches that frame. The bench therefore checks the victim index and the exact sweep length on every request.

The stimulus carries reference bits and the hand position across a chain of requests, and several of them wrap the ring. A stale bit, an off-by-one hand or a missed load mark therefore shows up within one or two requests. A collision between an access and a clear, and a request made during a sweep, each change the latency or add a stray pulse in the cycles that follow.

// File: rtl/clk_repl_pkg.sv
package clk_repl_pkg;
  typedef enum logic {
    SW_IDLE  = 1'b0,
    SW_SCAN  = 1'b1
  } sweep_state_t;
endpackage

// File: rtl/ref_bit_array.sv
module ref_bit_array #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_en,
  input  logic [IDX_W-1:0]    touch_idx,
  input  logic                load_en,
  input  logic [IDX_W-1:0]    load_idx,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  output logic [N_FRAMES-1:0] ref_bits
);
  logic [N_FRAMES-1:0] ref_q;
  logic [N_FRAMES-1:0] ref_d;
  logic [N_FRAMES-1:0] ref_we;

  // Set sources (access, load) take priority over the sweep clear.
  for (genvar g = 0; g < N_FRAMES; g++) begin : g_bit
    logic hit_touch, hit_load, hit_clr;
    always_comb begin
      hit_touch = touch_en && (touch_idx == IDX_W'(g));
      hit_load  = load_en  && (load_idx  == IDX_W'(g));
      hit_clr   = clr_en   && (clr_idx   == IDX_W'(g));
      ref_we[g] = hit_touch || hit_load || hit_clr;
      ref_d[g]  = hit_touch || hit_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ref_q[g] <= 1'b0;
      else if (ref_we[g]) ref_q[g] <= ref_d[g];
    end
  end

  assign ref_bits = ref_q;

  // R2: an access always leaves its frame referenced
  p_touch_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> ref_q[$past(touch_idx)]);

  // R8: an access that collides with a clear keeps the bit set
  p_touch_beats_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && clr_en && touch_idx == clr_idx) |=> ref_q[$past(clr_idx)]);
endmodule

// File: rtl/hand_ptr.sv
module hand_ptr #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  output logic [IDX_W-1:0] hand
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_FRAMES - 1);

  logic [IDX_W-1:0] hand_q;
  logic [IDX_W-1:0] hand_d;

  always_comb begin
    if (hand_q == LAST_IDX) hand_d = '0;
    else                    hand_d = hand_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hand_q <= '0;
    else if (adv_en) hand_q <= hand_d;
  end

  assign hand = hand_q;

  // R6: the hand wraps from the last frame back to frame 0
  p_hand_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_en && hand_q == LAST_IDX) |=> (hand_q == '0));

  p_hand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_en |=> $stable(hand_q));
endmodule

// File: rtl/sweep_ctrl.sv
module sweep_ctrl
  import clk_repl_pkg::*;
#(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             bit_at_hand,
  input  logic [IDX_W-1:0] hand,
  output logic             busy,
  output logic             adv_en,
  output logic             clr_en,
  output logic             load_en,
  output logic             done,
  output logic [IDX_W-1:0] victim
);
  sweep_state_t st_q, st_d;
  logic             done_q, done_d;
  logic [IDX_W-1:0] vic_q, vic_d;
  logic             found;

  always_comb begin
    found   = (st_q == SW_SCAN) && !bit_at_hand;
    adv_en  = (st_q == SW_SCAN);
    clr_en  = (st_q == SW_SCAN) && bit_at_hand;
    load_en = found;
    done_d  = found;
    vic_d   = found ? hand : vic_q;
    st_d    = st_q;
    case (st_q)
      SW_IDLE: if (req)   st_d = SW_SCAN;
      SW_SCAN: if (found) st_d = SW_IDLE;
      default:            st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SW_IDLE;
      done_q <= 1'b0;
      vic_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (found) vic_q <= vic_d;
    end
  end

  assign busy   = (st_q == SW_SCAN);
  assign done   = done_q;
  assign victim = vic_q;

  // R9: the completion pulse lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: a completion is always preceded by a busy cycle
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy));

  // R3: the reported frame is the one examined with a clear bit
  p_victim_was_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_at_hand) |=> (done_q && vic_q == $past(hand)));

  // R10: a request during a sweep neither restarts nor ends it
  p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bit_at_hand && req) |=> (busy && !done_q));
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int N_FRAMES = 8,
  localparam int IDX_W = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_valid,
  input  logic [IDX_W-1:0] touch_frame,
  input  logic             vsel_req,
  output logic             vsel_busy,
  output logic             vsel_done,
  output logic [IDX_W-1:0] vsel_frame
);
  logic [N_FRAMES-1:0] ref_bits;
  logic [IDX_W-1:0]    hand;
  logic                bit_at_hand;
  logic                adv_en, clr_en, load_en;

  assign bit_at_hand = ref_bits[hand];

  ref_bit_array #(.N_FRAMES(N_FRAMES)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_valid),
    .touch_idx (touch_frame),
    .load_en   (load_en),
    .load_idx  (hand),
    .clr_en    (clr_en),
    .clr_idx   (hand),
    .ref_bits  (ref_bits)
  );

  hand_ptr #(.N_FRAMES(N_FRAMES)) u_hand (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (adv_en),
    .hand   (hand)
  );

  sweep_ctrl #(.N_FRAMES(N_FRAMES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (vsel_req),
    .bit_at_hand (bit_at_hand),
    .hand        (hand),
    .busy        (vsel_busy),
    .adv_en      (adv_en),
    .clr_en      (clr_en),
    .load_en     (load_en),
    .done        (vsel_done),
    .victim      (vsel_frame)
  );

  // R5: the victim slot is marked referenced right after it is chosen
  p_victim_marked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ref_bits[$past(hand)]);
endmodule

// File: tb/test_clock_victim_sel.sv
`timescale 1ns/1ps
module test_clock_victim_sel;
  localparam int N = 8;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         touch_valid;
  logic [W-1:0] touch_frame;
  logic         vsel_req;
  logic         vsel_busy, vsel_done;
  logic [W-1:0] vsel_frame;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.N_FRAMES(N)) i_clock_victim_sel (
    .clk(clk), .rst_n(rst_n), .touch_valid(touch_valid), .touch_frame(touch_frame),
    .vsel_req(vsel_req), .vsel_busy(vsel_busy), .vsel_done(vsel_done),
    .vsel_frame(vsel_frame)
  );

  // Per entry: frames touched first, expected victim, expected frames examined.
  // The hand and the bits carry over from one entry to the next.
  localparam logic [7:0] V_MASK [8] = '{8'h00, 8'h06, 8'hF0, 8'hFF, 8'h08, 8'h00, 8'hC0, 8'h02};
  localparam int         V_VIC  [8] = '{0, 3, 1, 2, 4, 5, 0, 3};
  localparam int         V_LAT  [8] = '{1, 3, 6, 9, 2, 1, 3, 3};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic touch(input int f);
    @(negedge clk);
    touch_valid = 1'b1;
    touch_frame = W'(f);
    @(negedge clk);
    touch_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; touch_valid = 1'b0; touch_frame = '0; vsel_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Raises the request for one cycle, then counts the frames examined until done.
  task automatic request(output int lat, output int vic);
    @(negedge clk);
    vsel_req = 1'b1;
    @(negedge clk);
    vsel_req = 1'b0;
    check(vsel_busy === 1'b1, "R9 busy during sweep", int'(vsel_busy), 1);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!vsel_done && lat < 40);
    vic = int'(vsel_frame);
    @(negedge clk);
    check(vsel_done === 1'b0, "R9 done lasts one cycle", int'(vsel_done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, vic;
    do_reset();
    // R1: idle outputs right after reset
    check(vsel_busy === 1'b0, "R1 busy after reset", int'(vsel_busy), 0);
    check(vsel_done === 1'b0, "R1 done after reset", int'(vsel_done), 0);

    // R2 R3 R4 R5 R6 R7: chained clock sweeps, several wrapping the ring
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < N; f++) if (V_MASK[e][f]) touch(f);
      request(lat, vic);
      check(vic == V_VIC[e], $sformatf("R3/R4/R5/R6 entry %0d victim", e), vic, V_VIC[e]);
      check(lat == V_LAT[e], $sformatf("R2/R4/R7 entry %0d latency", e), lat, V_LAT[e]);
    end

    // R1: a fresh reset returns frame 0 in one step
    do_reset();
    request(lat, vic);
    check(vic == 0, "R1 victim after reset", vic, 0);
    check(lat == 1, "R1 latency after reset", lat, 1);

    // R10 and R7: all bits set, a second request during the sweep is ignored
    do_reset();
    for (int f = 0; f < N; f++) touch(f);
    @(negedge clk);
    vsel_req = 1'b1;
    @(negedge clk);
    vsel_req = 1'b0;
    repeat (2) @(negedge clk);
    vsel_req = 1'b1;
    @(negedge clk);
    vsel_req = 1'b0;
    lat = 3;
    while (!vsel_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(int'(vsel_frame) == 0, "R7 full-ring victim", int'(vsel_frame), 0);
    check(lat == N + 1, "R7 full-ring latency", lat, N + 1);
    begin
      int extra = 0;
      for (int c = 0; c < 12; c++) begin
        @(negedge clk);
        if (vsel_done || vsel_busy) extra++;
      end
      check(extra == 0, "R10 request while busy ignored", extra, 0);
    end

    // R8: an access to frame 0 in the cycle its bit is cleared keeps it set
    do_reset();
    for (int f = 0; f < N; f++) touch(f);
    @(negedge clk);
    vsel_req = 1'b1;
    @(negedge clk);
    vsel_req = 1'b0;
    touch_valid = 1'b1;
    touch_frame = '0;
    @(negedge clk);
    touch_valid = 1'b0;
    lat = 1;
    while (!vsel_done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(int'(vsel_frame) == 1, "R8 collision victim", int'(vsel_frame), 1);
    check(lat == N + 2, "R8 collision latency", lat, N + 2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule